// File: doc/BRIEF.md
# Power-Mode-Aware Watchdog Timer

This block is the watchdog of a small microcontroller. A free-running counter advances on the system clock-enable tick. If software does not clear it with a kick strobe before it reaches its terminal value, the block raises a one-clock reset pulse and starts counting again from zero.

Whether the counter runs at all depends on two things:

- **A two-bit option word.** It is captured while reset is held and stays fixed until the next reset.
- **The current power mode** of the core: normal, slow, green or sleep.

The option selects one of three behaviours:

- **Off.** The watchdog never counts and never fires.
- **Gated.** The watchdog counts only while the core is in normal or slow mode, and holds its value in green and sleep.
- **Always on.** The watchdog counts in every power mode.

The block also filters the core's sleep request. In always-on mode, sleep is never granted, so the watchdog cannot be stopped by putting the core to sleep. In the other modes, the request passes through unchanged.

Top module: `pwrmode_watchdog`

## Requirements
- R1: After reset, the counter is zero and `wdtRst` is low.
- R2: `cfgMode` is sampled on every clock edge while `rstN` is low, and the last sampled value is held until the next reset. Changes to `cfgMode` while `rstN` is high have no effect. The encodings are: 2'b00 off, 2'b01 gated, 2'b10 always on, and 2'b11 behaves as off.
- R3: In gated mode, the counter advances only when `pwrMode` is 2'b00 (normal) or 2'b01 (slow). When `pwrMode` is 2'b10 (green) or 2'b11 (sleep), the counter holds its value.
- R4: In always-on mode, the counter advances in all four power modes.
- R5: In off mode, the counter stays at zero and `wdtRst` never rises.
- R6: A tick that would advance the counter while it holds `TERM_VAL` instead reloads it to zero. On the next clock, `wdtRst` is high for exactly one cycle. Starting from zero, the pulse therefore follows the (`TERM_VAL`+1)-th advancing tick.
- R7: A kick clears the counter to zero in any mode. A kick takes priority over a terminal event in the same cycle, so no pulse is produced.
- R8: The counter does not change on cycles where `tick` is low.
- R9: `sleepGrant` is held low in always-on mode. In every other mode it equals `sleepReq` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset; `cfgMode` is captured while it is low |
| cfgMode | input | 2 | Watchdog option word from configuration |
| pwrMode | input | 2 | Current power mode: 00 normal, 01 slow, 10 green, 11 sleep |
| sleepReq | input | 1 | Request from the core to enter sleep |
| kick | input | 1 | Clear strobe from software |
| tick | input | 1 | Clock-enable tick that paces the counter |
| wdtRst | output | 1 | One-clock watchdog reset pulse |
| sleepGrant | output | 1 | Filtered sleep request |

## Verification
The bench builds the block with `CNT_W` = 8 and `TERM_VAL` = 5. At these values a time-out needs only six advancing ticks, so several complete expiry, freeze and kick sequences fit in a few hundred cycles.

A per-cycle vector table, run in gated mode, walks through all four power modes, idle ticks, kicks before expiry and a kick that lands on the terminal cycle. Directed tests then exercise the remaining cases:

- the always-on mode while the core is asleep;
- both encodings that select off;
- an option change made after reset, which must be ignored.

// File: rtl/pwrmode_watchdog_pkg.sv
`timescale 1ns/1ps
package pwrmode_watchdog_pkg;

  typedef enum logic [1:0] {
    WDOG_OFF     = 2'b00,
    WDOG_GATED   = 2'b01,
    WDOG_ALWAYS  = 2'b10,
    WDOG_OFF_ALT = 2'b11
  } wdogMode_e;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_SLOW   = 2'b01,
    PM_GREEN  = 2'b10,
    PM_SLEEP  = 2'b11
  } pwrMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clr;   // kick: force counter to zero
    logic inc;   // advance by one
    logic wrap;  // terminal event: reload and fire
  } cntCmd_t;

endpackage

// File: rtl/pwrmode_watchdog_ctrl.sv
`timescale 1ns/1ps
module pwrmode_watchdog_ctrl
  import pwrmode_watchdog_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic [1:0] cfgMode,
  input  logic [1:0] pwrMode,
  input  logic      sleepReq,
  input  logic      kick,
  input  logic      tick,
  input  logic      atTerm,
  output cntCmd_t   cmd,
  output logic      sleepGrant,
  output wdogMode_e modeQ
);

  logic runOk;
  logic advance;
  pwrMode_e pm;

  // Option capture: tracks cfgMode while reset is held (R2)
  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= wdogMode_e'(cfgMode);
  end

  assign pm = pwrMode_e'(pwrMode);

  // Per-mode run permission (R3, R4, R5)
  always_comb begin
    unique case (modeQ)
      WDOG_ALWAYS: runOk = 1'b1;
      WDOG_GATED:  runOk = (pm == PM_NORMAL) || (pm == PM_SLOW);
      default:     runOk = 1'b0;
    endcase
  end

  // Kick outranks everything (R7); tick paces advance (R8)
  assign advance  = runOk && tick && !kick;
  assign cmd.clr  = kick;
  assign cmd.wrap = advance && atTerm;
  assign cmd.inc  = advance && !atTerm;

  // Sleep filter (R9)
  assign sleepGrant = (modeQ == WDOG_ALWAYS) ? 1'b0 : sleepReq;

endmodule

// File: rtl/pwrmode_watchdog_cnt.sv
`timescale 1ns/1ps
module pwrmode_watchdog_cnt
  import pwrmode_watchdog_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned TERM_VAL = (1 << CNT_W) - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  output logic             atTerm,
  output logic             firePulse,
  output logic [CNT_W-1:0] cntVal
);

  localparam logic [CNT_W-1:0] TERM_C = TERM_VAL[CNT_W-1:0];
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  assign atTerm = (cntVal == TERM_C);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal    <= '0;
      firePulse <= 1'b0;
    end else begin
      firePulse <= cmd.wrap;
      if (cmd.clr || cmd.wrap) cntVal <= '0;
      else if (cmd.inc)        cntVal <= cntVal + ONE_C;
    end
  end

endmodule

// File: rtl/pwrmode_watchdog.sv
`timescale 1ns/1ps
module pwrmode_watchdog
  import pwrmode_watchdog_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned TERM_VAL = (1 << CNT_W) - 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cfgMode,
  input  logic [1:0] pwrMode,
  input  logic       sleepReq,
  input  logic       kick,
  input  logic       tick,
  output logic       wdtRst,
  output logic       sleepGrant
);

  cntCmd_t          cmd;
  logic             atTerm;
  wdogMode_e        modeQ;
  logic [CNT_W-1:0] cntVal;

  pwrmode_watchdog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .pwrMode(pwrMode),
    .sleepReq(sleepReq), .kick(kick), .tick(tick), .atTerm(atTerm),
    .cmd(cmd), .sleepGrant(sleepGrant), .modeQ(modeQ)
  );

  pwrmode_watchdog_cnt #(.CNT_W(CNT_W), .TERM_VAL(TERM_VAL)) u_cnt (
    .clk(clk), .rstN(rstN), .cmd(cmd), .atTerm(atTerm),
    .firePulse(wdtRst), .cntVal(cntVal)
  );

endmodule

// File: rtl/pwrmode_watchdog_chk.sv
`timescale 1ns/1ps
module pwrmode_watchdog_chk #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned TERM_VAL = (1 << CNT_W) - 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       pwrMode,
  input logic             sleepReq,
  input logic             kick,
  input logic             tick,
  input logic             wdtRst,
  input logic             sleepGrant,
  input logic [1:0]       modeQ,
  input logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] TERM_C = TERM_VAL[CNT_W-1:0];
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(modeQ));

  assert_gated_freeze_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'b01 && pwrMode[1] && !kick) |=> $stable(cnt));

  assert_always_runs_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'b10 && tick && !kick && cnt != TERM_C) |=> (cnt == $past(cnt) + ONE_C));

  assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'b00 || modeQ == 2'b11) |-> (cnt == '0 && !wdtRst));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    wdtRst |=> !wdtRst);

  assert_reload_on_fire_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdtRst) |-> (cnt == '0));

  assert_kick_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    kick |=> (cnt == '0 && !wdtRst));

  assert_no_tick_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !kick) |=> $stable(cnt));

  assert_sleep_veto_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'b10) |-> !sleepGrant);

  assert_sleep_pass_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != 2'b10) |-> (sleepGrant == sleepReq));

endmodule

bind pwrmode_watchdog pwrmode_watchdog_chk #(.CNT_W(CNT_W), .TERM_VAL(TERM_VAL)) u_chk (
  .clk(clk), .rstN(rstN), .pwrMode(pwrMode), .sleepReq(sleepReq),
  .kick(kick), .tick(tick), .wdtRst(wdtRst), .sleepGrant(sleepGrant),
  .modeQ(modeQ), .cnt(cntVal)
);

// File: tb/pwrmode_watchdog_tb.sv
`timescale 1ns/1ps
module pwrmode_watchdog_tb;

  localparam int unsigned CNT_W    = 8;
  localparam int unsigned TERM_VAL = 5;
  localparam logic H = 1'b1;
  localparam logic L = 1'b0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cfgMode = 2'b01;
  logic [1:0] pwrMode = 2'b00;
  logic sleepReq = 1'b0, kick = 1'b0, tick = 1'b0;
  logic wdtRst, sleepGrant;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pwrmode_watchdog #(.CNT_W(CNT_W), .TERM_VAL(TERM_VAL)) u_dut (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .pwrMode(pwrMode),
    .sleepReq(sleepReq), .kick(kick), .tick(tick),
    .wdtRst(wdtRst), .sleepGrant(sleepGrant)
  );

  typedef struct packed {
    logic [1:0] pwr;
    logic       tk;
    logic       kk;
    logic       rq;
    logic       eRst;
    logic       eGnt;
    logic [3:0] tag;
  } vec_t;

  // Gated mode, TERM_VAL=5: pulse on 6th advancing tick from zero
  localparam vec_t VEC [25] = '{
    '{2'd0, H, L, L, L, L, 4'd3},  // c1
    '{2'd1, H, L, L, L, L, 4'd3},  // c2 slow
    '{2'd2, H, L, H, L, H, 4'd3},  // green frozen, grant passes
    '{2'd3, H, L, H, L, H, 4'd3},  // sleep frozen
    '{2'd0, L, L, L, L, L, 4'd8},  // no tick
    '{2'd0, H, L, L, L, L, 4'd3},  // c3
    '{2'd1, H, L, L, L, L, 4'd3},  // c4
    '{2'd0, H, L, L, L, L, 4'd3},  // c5
    '{2'd2, H, L, L, L, L, 4'd3},  // frozen at terminal
    '{2'd0, H, L, L, H, L, 4'd6},  // fire
    '{2'd0, L, L, L, L, L, 4'd6},  // pulse one cycle only
    '{2'd0, H, L, H, L, H, 4'd9},  // c1, grant passes
    '{2'd0, H, H, L, L, L, 4'd7},  // kick -> c0
    '{2'd0, H, L, L, L, L, 4'd7},
    '{2'd0, H, L, L, L, L, 4'd7},
    '{2'd0, H, L, L, L, L, 4'd7},
    '{2'd0, H, L, L, L, L, 4'd7},
    '{2'd0, H, L, L, L, L, 4'd7},  // c5
    '{2'd0, H, H, L, L, L, 4'd7},  // kick on terminal: no fire
    '{2'd0, H, L, L, L, L, 4'd6},
    '{2'd0, H, L, L, L, L, 4'd6},
    '{2'd0, H, L, L, L, L, 4'd6},
    '{2'd0, H, L, L, L, L, 4'd6},
    '{2'd0, H, L, L, L, L, 4'd6},  // c5
    '{2'd0, H, L, L, H, L, 4'd6}   // fire
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] mode);
    @(negedge clk);
    rstN = 1'b0; cfgMode = mode; tick = 1'b0; kick = 1'b0; sleepReq = 1'b0;
    pwrMode = 2'b00;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic step(input logic [1:0] pw, input logic tk, input logic kk, input logic rq);
    @(negedge clk);
    pwrMode = pw; tick = tk; kick = kk; sleepReq = rq;
    @(posedge clk);
    #1;
  endtask

  // Runs n steps and returns how many had wdtRst high
  task automatic runTicks(input int n, input logic [1:0] pw, input logic tk,
                          input logic rq, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      step(pw, tk, 1'b0, rq);
      if (wdtRst) pulses++;
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
  endtask

  initial begin
    int p;
    // R1: reset state
    doReset(2'b01);
    @(posedge clk); #1;
    chk("R1 wdtRst low after reset", wdtRst, 1'b0);

    // Vector table in gated mode (R3 R6 R7 R8 R9)
    for (int i = 0; i < 25; i++) begin
      step(VEC[i].pwr, VEC[i].tk, VEC[i].kk, VEC[i].rq);
      chk($sformatf("R%0d vec %0d wdtRst", VEC[i].tag, i), wdtRst, VEC[i].eRst);
      chk($sformatf("R%0d vec %0d sleepGrant", VEC[i].tag, i), sleepGrant, VEC[i].eGnt);
    end

    // R4 and R9: always on, counting while asleep, sleep vetoed
    doReset(2'b10);
    runTicks(5, 2'b11, 1'b1, 1'b1, p);
    chk("R4 no fire before terminal in sleep", (p == 0), 1'b1);
    chk("R9 grant vetoed in always-on", sleepGrant, 1'b0);
    step(2'b11, 1'b1, 1'b0, 1'b1);
    chk("R4 fire while asleep", wdtRst, 1'b1);
    runTicks(5, 2'b10, 1'b1, 1'b0, p);
    step(2'b10, 1'b1, 1'b0, 1'b0);
    chk("R4 fire while green", wdtRst, 1'b1);

    // R8: no tick, no progress (always on)
    doReset(2'b10);
    runTicks(20, 2'b00, 1'b0, 1'b0, p);
    runTicks(5, 2'b00, 1'b1, 1'b0, p);
    chk("R8 idle cycles did not advance", (p == 0), 1'b1);
    step(2'b00, 1'b1, 1'b0, 1'b0);
    chk("R8 sixth tick fires", wdtRst, 1'b1);

    // R7: kick in always-on while asleep
    doReset(2'b10);
    runTicks(5, 2'b11, 1'b1, 1'b0, p);
    step(2'b11, 1'b1, 1'b1, 1'b0);
    chk("R7 kick on terminal suppresses fire", wdtRst, 1'b0);
    runTicks(5, 2'b11, 1'b1, 1'b0, p);
    chk("R7 count restarted from zero", (p == 0), 1'b1);
    step(2'b11, 1'b1, 1'b0, 1'b0);
    chk("R7 fire after full count post-kick", wdtRst, 1'b1);

    // R5: off mode never fires, grant passes
    doReset(2'b00);
    runTicks(20, 2'b00, 1'b1, 1'b1, p);
    chk("R5 off mode no pulse", (p == 0), 1'b1);
    chk("R9 grant passes in off mode", sleepGrant, 1'b1);

    // R2: encoding 11 acts as off
    doReset(2'b11);
    runTicks(20, 2'b01, 1'b1, 1'b1, p);
    chk("R2 encoding 11 no pulse", (p == 0), 1'b1);
    chk("R2 encoding 11 grant passes", sleepGrant, 1'b1);

    // R2: option change after reset ignored
    doReset(2'b00);
    @(negedge clk); cfgMode = 2'b10;
    runTicks(20, 2'b00, 1'b1, 1'b1, p);
    chk("R2 late option change: still no pulse", (p == 0), 1'b1);
    chk("R2 late option change: grant still passes", sleepGrant, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog timeout: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule